// File: doc/BRIEF.md
# Six-Channel Programmable Priority Arbiter

This block decides which of six DMA channel requesters gets the local bus next. Each channel raises a request line. The arbiter answers with a one-hot grant and holds it until the granted transfer signals completion on a done strobe. A small register port holds three control values: a mode bit, a ranked channel list for fixed priority, and a table of 4-bit weights for weighted round-robin. The arbiter leaves reset in weighted round-robin mode with equal weights.

Control is a two-state machine. IDLE drives no grant. When any request is present it takes the ARBITRATE transition, which loads a grant and enters HOLD. HOLD keeps the grant steady. The done strobe takes the RELEASE transition back to IDLE and drops the grant for one cycle, and the next decision follows. In fixed mode, the ranked list sets the order. In round-robin mode, each channel holds a credit counter loaded from its weight plus one. The pick rotates past the last granted channel and skips channels that have used up their credit. All credits reload when no requesting channel has any credit left.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset the grant is zero. The registers read mode = 0 at address 0, order = 0x00543210 at address 1, and weights = 0 at address 2.
- R2: A write with cfg_we high stores cfg_wdata at cfg_addr on the clock edge. Mode keeps bit 0 only. Order and weights keep bits [23:0] only. Unused bits and address 3 read as zero.
- R3: In IDLE with any request present, the grant becomes one-hot on the next edge and names a channel that was requesting at that edge. The grant is never more than one-hot.
- R4: In HOLD the grant does not change until done_i is high at an edge, whatever the requests do. done_i in IDLE has no effect.
- R5: done_i in HOLD clears the grant at that edge. The next grant appears no earlier than one edge later.
- R6: With mode = 1, field k at bits [4k+3:4k] of the order register names the channel of rank k, where rank 0 is highest. The requesting channel of best rank is granted. For example, order 0x00431520 ranks channels 0, 2, 5, 1, 3, 4.
- R7: An order field holding a value above 5, or a channel already named at a better rank, is ignored. Channels left unnamed rank below all named ones, in ascending index order.
- R8: With mode = 0, channel n takes weight field bits [4n+3:4n]. Over one credit period with all six channels requesting, channel n receives field+1 grants. For example, weights 0x20F100 give 1, 1, 2, 16, 1 and 3 grants out of 24.
- R9: In round-robin mode the pick is the first requesting channel with credit, searching upward from the channel after the last granted one and wrapping. After reset that search starts at channel 0.
- R10: A requesting channel with no credit is passed over while another requesting channel holds credit. When no requesting channel holds credit, every credit reloads to weight+1 and the same decision uses the reloaded values.
- R11: A write to mode, order or weights during HOLD leaves the current grant unchanged. The new value governs the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 6 | Request line per channel |
| done_i | input | 1 | Transfer-complete strobe that releases the grant |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select: 0 mode, 1 order, 2 weights |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| grant_o | output | 6 | One-hot grant |

## Verification
A wrong credit counter or rotation pointer does not show as an illegal grant. It shows as a legal grant to the wrong channel, often one or more credit periods after the bad state arose. For that reason the bench models credits and pointer on its own and compares every grant cycle by cycle, and it also counts grants over a full 24-grant period. A fault in the order decode shows on the very next decision, so it is checked with directed request masks chosen to separate adjacent ranks, duplicate fields and out-of-range fields. A fault in the state machine shows within one or two cycles, as a grant that moves while held or that fails to drop on release.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
    parameter int unsigned NCH = 6;
    parameter int unsigned FW  = 4;
    parameter int unsigned DW  = 32;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } arb_state_e;

    typedef enum logic [1:0] {
        RA_MODE   = 2'd0,
        RA_ORDER  = 2'd1,
        RA_WEIGHT = 2'd2,
        RA_NONE   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/arb_regs.sv
`timescale 1ns/1ps
module arb_regs
    import arb_pkg::*;
#(
    parameter int unsigned N = NCH,
    parameter int unsigned F = FW,
    parameter int unsigned D = DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wen,
    input  logic [1:0]     addr,
    input  logic [D-1:0]   wdata,
    output logic [D-1:0]   rdata,
    output logic           mode_o,
    output logic [N*F-1:0] order_o,
    output logic [N*F-1:0] weight_o
);
    localparam int unsigned LW = N * F;

    function automatic logic [LW-1:0] identity_order();
        logic [LW-1:0] r;
        r = '0;
        for (int i = 0; i < int'(N); i++) begin
            r[i*F +: F] = F'(i);
        end
        return r;
    endfunction

    localparam logic [LW-1:0] ORDER_RST = identity_order();

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o   <= 1'b0;
            order_o  <= ORDER_RST;
            weight_o <= '0;
        end else if (wen) begin
            case (reg_addr_e'(addr))
                RA_MODE:   mode_o   <= wdata[0];
                RA_ORDER:  order_o  <= wdata[LW-1:0];
                RA_WEIGHT: weight_o <= wdata[LW-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            RA_MODE:   rdata[0]      = mode_o;
            RA_ORDER:  rdata[LW-1:0] = order_o;
            RA_WEIGHT: rdata[LW-1:0] = weight_o;
            default:   rdata         = '0;
        endcase
    end
endmodule

// File: rtl/arb_fixed_pick.sv
`timescale 1ns/1ps
module arb_fixed_pick
    import arb_pkg::*;
#(
    parameter int unsigned N = NCH,
    parameter int unsigned F = FW,
    localparam int unsigned PW = $clog2(N)
) (
    input  logic [N-1:0]   req,
    input  logic [N*F-1:0] order,
    output logic           valid,
    output logic [PW-1:0]  idx
);
    logic [N-1:0] named;
    logic [F-1:0] fld;
    logic         found;

    always_comb begin
        named = '0;
        found = 1'b0;
        idx   = '0;
        fld   = '0;
        // ranked fields first: skip out-of-range and repeated channels
        for (int r = 0; r < int'(N); r++) begin
            fld = order[r*F +: F];
            if (int'(fld) < int'(N) && !named[fld[PW-1:0]]) begin
                if (!found && req[fld[PW-1:0]]) begin
                    found = 1'b1;
                    idx   = fld[PW-1:0];
                end
                named[fld[PW-1:0]] = 1'b1;
            end
        end
        // unnamed channels trail in ascending order
        for (int c = 0; c < int'(N); c++) begin
            if (!found && req[c] && !named[c]) begin
                found = 1'b1;
                idx   = PW'(c);
            end
        end
        valid = found;
    end
endmodule

// File: rtl/arb_wrr_pick.sv
`timescale 1ns/1ps
module arb_wrr_pick
    import arb_pkg::*;
#(
    parameter int unsigned N = NCH,
    parameter int unsigned F = FW,
    localparam int unsigned PW = $clog2(N),
    localparam int unsigned CW = F + 1
) (
    input  logic [N-1:0]    req,
    input  logic [N*CW-1:0] credit,
    input  logic [N*F-1:0]  weight,
    input  logic [PW-1:0]   last,
    output logic            valid,
    output logic [PW-1:0]   idx,
    output logic [N*CW-1:0] credit_nx
);
    logic [CW-1:0] eff [N];
    logic          any_live;
    logic          found;
    int            c;

    always_comb begin
        any_live = 1'b0;
        for (int k = 0; k < int'(N); k++) begin
            if (req[k] && credit[k*CW +: CW] != '0) any_live = 1'b1;
        end
        for (int k = 0; k < int'(N); k++) begin
            eff[k] = any_live ? credit[k*CW +: CW]
                              : CW'(weight[k*F +: F]) + CW'(1);
        end
        found = 1'b0;
        idx   = '0;
        c     = 0;
        for (int off = 1; off <= int'(N); off++) begin
            c = (int'(last) + off) % int'(N);
            if (!found && req[c] && eff[c] != '0) begin
                found = 1'b1;
                idx   = PW'(c);
            end
        end
        valid = found;
        for (int k = 0; k < int'(N); k++) begin
            credit_nx[k*CW +: CW] = (found && idx == PW'(k)) ? eff[k] - CW'(1) : eff[k];
        end
    end
endmodule

// File: rtl/dma_prio_arbiter.sv
`timescale 1ns/1ps
module dma_prio_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned N = NCH,
    parameter int unsigned F = FW,
    parameter int unsigned D = DW,
    localparam int unsigned PW = $clog2(N),
    localparam int unsigned CW = F + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         done_i,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_addr,
    input  logic [D-1:0] cfg_wdata,
    output logic [D-1:0] cfg_rdata,
    output logic [N-1:0] grant_o
);
    arb_state_e      state, state_nx;
    logic            mode;
    logic [N*F-1:0]  order, weight;
    logic [N*CW-1:0] credit, credit_nx;
    logic [PW-1:0]   last;
    logic            fix_valid, wrr_valid, pick_valid;
    logic [PW-1:0]   fix_idx, wrr_idx, pick_idx;
    logic            decide;

    arb_regs #(.N(N), .F(F), .D(D)) u_regs (
        .clk(clk), .rst_n(rst_n), .wen(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .mode_o(mode), .order_o(order), .weight_o(weight)
    );

    arb_fixed_pick #(.N(N), .F(F)) u_fixed (
        .req(req_i), .order(order), .valid(fix_valid), .idx(fix_idx)
    );

    arb_wrr_pick #(.N(N), .F(F)) u_wrr (
        .req(req_i), .credit(credit), .weight(weight), .last(last),
        .valid(wrr_valid), .idx(wrr_idx), .credit_nx(credit_nx)
    );

    assign pick_valid = mode ? fix_valid : wrr_valid;
    assign pick_idx   = mode ? fix_idx   : wrr_idx;
    assign decide     = (state == ST_IDLE) && pick_valid;

    // next-state decode: ARBITRATE and RELEASE transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (pick_valid) state_nx = ST_HOLD;
            ST_HOLD: if (done_i)     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    function automatic logic [N*CW-1:0] credit_reset();
        logic [N*CW-1:0] r;
        for (int k = 0; k < int'(N); k++) r[k*CW +: CW] = CW'(1);
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_o <= '0;
            last    <= PW'(N - 1);
            credit  <= credit_reset();
        end else begin
            unique case (state)
                ST_IDLE: if (decide) begin
                    grant_o <= N'(1) << pick_idx;
                    last    <= pick_idx;
                    if (!mode) credit <= credit_nx;
                end
                ST_HOLD: if (done_i) grant_o <= '0;
            endcase
        end
    end

    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_grant_to_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_i != '0) |=> ((grant_o & $past(req_i)) != '0));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !done_i) |=> $stable(grant_o));

    assert_release_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && done_i) |=> (grant_o == '0));

    assert_idle_no_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (grant_o == '0));
endmodule

// File: tb/dma_prio_arbiter_test.sv
`timescale 1ns/1ps
module dma_prio_arbiter_test;
    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  req = '0;
    logic        rel = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  grant;

    int checks = 0;
    int errors = 0;

    // bench-side model of the requirements
    logic        m_mode = 1'b0;
    logic [23:0] m_order = 24'h543210;
    logic [23:0] m_wt = 24'h0;
    logic        m_hold = 1'b0;
    logic [5:0]  m_grant = '0;
    int          m_cred [6] = '{1, 1, 1, 1, 1, 1};
    int          m_last = 5;

    dma_prio_arbiter uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(rel),
        .cfg_we(reg_we), .cfg_addr(reg_addr), .cfg_wdata(reg_wdata),
        .cfg_rdata(reg_rdata), .grant_o(grant)
    );

    always #(CLK_NS / 2.0) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_fixed(input logic [5:0] rq, input logic [23:0] ord);
        logic [5:0] seen = '0;
        int pick = -1;
        for (int r = 0; r < 6; r++) begin
            int f = int'(ord[r*4 +: 4]);
            if (f <= 5 && !seen[f]) begin
                seen[f] = 1'b1;
                if (pick < 0 && rq[f]) pick = f;
            end
        end
        for (int c = 0; c < 6; c++) if (pick < 0 && rq[c] && !seen[c]) pick = c;
        return pick;
    endfunction

    function automatic int exp_wrr(input logic [5:0] rq);
        bit live = 0;
        int pick = -1;
        for (int c = 0; c < 6; c++) if (rq[c] && m_cred[c] > 0) live = 1;
        if (!live) for (int c = 0; c < 6; c++) m_cred[c] = int'(m_wt[c*4 +: 4]) + 1;
        for (int off = 1; off <= 6; off++) begin
            int c = (m_last + off) % 6;
            if (pick < 0 && rq[c] && m_cred[c] > 0) pick = c;
        end
        if (pick >= 0) m_cred[pick]--;
        return pick;
    endfunction

    task automatic model_edge(input logic [5:0] rq, input logic rl, input logic we,
                              input logic [1:0] ad, input logic [31:0] wd);
        if (m_hold) begin
            if (rl) begin m_hold = 1'b0; m_grant = '0; end
        end else if (rq != '0) begin
            int w = m_mode ? exp_fixed(rq, m_order) : exp_wrr(rq);
            m_grant = 6'(1) << w;
            m_hold = 1'b1;
            m_last = w;
        end
        if (we) begin
            case (ad)
                2'd0: m_mode = wd[0];
                2'd1: m_order = wd[23:0];
                2'd2: m_wt = wd[23:0];
                default: ;
            endcase
        end
    endtask

    task automatic step(input logic [5:0] rq, input logic rl, input logic we,
                        input logic [1:0] ad, input logic [31:0] wd, input string tag);
        req = rq; rel = rl; reg_we = we; reg_addr = ad; reg_wdata = wd;
        model_edge(rq, rl, we, ad, wd);
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; rel = 1'b0;
        check(tag, 32'(grant), 32'(m_grant));
    endtask

    task automatic wr(input logic [1:0] ad, input logic [31:0] wd, input string tag);
        step('0, 1'b0, 1'b1, ad, wd, tag);
    endtask

    task automatic rd(input logic [1:0] ad, input logic [31:0] exp, input string tag);
        reg_addr = ad;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    // one decision then release; returns the granted channel
    task automatic grant_once(input logic [5:0] rq, input string tag, output int ch);
        step(rq, 1'b0, 1'b0, 2'd0, 32'd0, tag);
        ch = -1;
        for (int c = 0; c < 6; c++) if (grant[c]) ch = c;
        step(rq, 1'b1, 1'b0, 2'd0, 32'd0, tag);
    endtask

    initial begin
        #(CLK_NS * 200000.0);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ch;
        int cnt [6];
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        check("R1 grant", 32'(grant), 32'h0);
        rd(2'd0, 32'h0, "R1 mode");
        rd(2'd1, 32'h00543210, "R1 order");
        rd(2'd2, 32'h0, "R1 weights");

        // R4: release while idle does nothing
        step('0, 1'b1, 1'b0, 2'd0, 32'd0, "R4 idle release");

        // R9: equal weights, all requesting, rotation from channel 0
        for (int i = 0; i < 6; i++) begin
            grant_once(6'h3F, "R9 rotate", ch);
            check("R9 order", 32'(ch), 32'(i));
        end

        // R2 register access
        wr(2'd2, 32'hFF20F100, "R2 write");
        rd(2'd2, 32'h0020F100, "R2 weights masked");
        wr(2'd0, 32'hFFFFFFFE, "R2 write");
        rd(2'd0, 32'h0, "R2 mode bit0");
        rd(2'd3, 32'h0, "R2 addr3");

        // R8 shares over one credit period
        for (int c = 0; c < 6; c++) cnt[c] = 0;
        for (int i = 0; i < 24; i++) begin
            grant_once(6'h3F, "R8 wrr", ch);
            if (ch >= 0) cnt[ch]++;
        end
        check("R8 ch0", 32'(cnt[0]), 32'd1);
        check("R8 ch1", 32'(cnt[1]), 32'd1);
        check("R8 ch2", 32'(cnt[2]), 32'd2);
        check("R8 ch3", 32'(cnt[3]), 32'd16);
        check("R8 ch4", 32'(cnt[4]), 32'd1);
        check("R8 ch5", 32'(cnt[5]), 32'd3);

        // R10 reload when requesters are out of credit, skip while others hold it
        grant_once(6'h01, "R10 reload", ch);
        check("R10 reload ch0", 32'(ch), 32'd0);
        grant_once(6'h01, "R10 reload", ch);
        check("R10 reload again", 32'(ch), 32'd0);
        grant_once(6'h09, "R10 skip", ch);
        check("R10 pass over ch0", 32'(ch), 32'd3);

        // R6 fixed ranking
        wr(2'd0, 32'h1, "R6 mode");
        wr(2'd1, 32'h00431520, "R6 order");
        grant_once(6'h3F, "R6", ch); check("R6 all", 32'(ch), 32'd0);
        grant_once(6'h3E, "R6", ch); check("R6 no0", 32'(ch), 32'd2);
        grant_once(6'h1A, "R6", ch); check("R6 1,3,4", 32'(ch), 32'd1);
        grant_once(6'h18, "R6", ch); check("R6 3,4", 32'(ch), 32'd3);

        // R7 invalid and duplicate fields
        wr(2'd1, 32'h009933F4, "R7 order");
        grant_once(6'h3F, "R7", ch); check("R7 all", 32'(ch), 32'd4);
        grant_once(6'h29, "R7", ch); check("R7 0,3,5", 32'(ch), 32'd3);
        grant_once(6'h27, "R7", ch); check("R7 unnamed", 32'(ch), 32'd0);
        grant_once(6'h24, "R7", ch); check("R7 2,5", 32'(ch), 32'd2);

        // R11 write during hold: grant kept, new order used next
        wr(2'd1, 32'h00543210, "R11 order");
        step(6'h3F, 1'b0, 1'b0, 2'd0, 32'd0, "R11 grant");
        step(6'h3F, 1'b0, 1'b1, 2'd1, 32'h00012345, "R11 hold write");
        check("R11 grant kept", 32'(grant), 32'h01);
        step(6'h00, 1'b0, 1'b0, 2'd0, 32'd0, "R4 hold no req");
        step(6'h3F, 1'b1, 1'b0, 2'd0, 32'd0, "R5 release");
        check("R5 dropped", 32'(grant), 32'h0);
        grant_once(6'h3F, "R11", ch); check("R11 new order", 32'(ch), 32'd5);

        // random mix across modes
        for (int i = 0; i < 800; i++) begin
            logic [5:0] rq = 6'($urandom);
            logic rl = ($urandom % 3) != 0;
            if ($urandom % 10 == 0)
                step(rq, rl, 1'b1, 2'($urandom % 3), $urandom, "R3 R6 R8 R11 random");
            else
                step(rq, rl, 1'b0, 2'd0, 32'd0, "R3 R4 R5 R9 R10 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule